// File: doc/BRIEF.md
# USB Host Command Register with Interrupt Pacing and Async-Advance Doorbell

This block holds the 32-bit command word of a USB 2.0 host controller, together with the logic that depends on it directly. It decodes the word into an interrupt pacing threshold, an asynchronous schedule enable and an async-advance doorbell. Software uses the doorbell to ask the schedule engine to drop its cached schedule state. When the engine pulses `adv_done`, the block posts the async-advance status bit and only then lets the doorbell fall.

The block also keeps a small bank of write-one-to-clear status bits. It counts 125 µs micro-frame ticks in windows of the programmed size, and it raises its single interrupt line only at a window end, and only if an enabled status bit is pending. Every pin is plain control or status. No data streams through the block, so there is no valid/ready interface and no back-pressure. A register write takes effect at the clock edge where `cmd_wr_en` is sampled high, and reads are combinational from the stored fields.

Top module: `usb_cmd_pacer`

## Requirements
- R1: After reset, `cmd_rd_data` is 32'h0008_0000 (threshold 8, all control bits 0), and `sts_q` and `irq` are 0.
- R2: Bits 23:16 of a command write load the threshold only if the value is one of 8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20 or 8'h40, meaning 1 to 64 micro-frames. Any other value leaves the previous threshold in place.
- R3: Bits 31:24, 15:8 (including the park-mode field 10:8), 7 (light reset), 4:2, 1 and 0 always read as 0, and writing them changes nothing except the controller-reset action of R10.
- R4: Bit 5 stores the asynchronous schedule enable. It is loaded by every command write that is not a controller reset, and it drives `sched_async_en`.
- R5: Bit 6 is the doorbell. A write with bit 6 = 1 sets it only if `sched_async_en` is already 1 before that edge. A write with bit 6 = 0 never clears it.
- R6: An `adv_done` pulse while the doorbell is set sets status bit ASYNC_IDX (`async_adv_sts`) and clears the doorbell at the same edge. An `adv_done` pulse while the doorbell is clear has no effect.
- R7: Each status bit other than ASYNC_IDX is set by a pulse on its bit of `evt_set`, and `evt_set[ASYNC_IDX]` is ignored. A status bit is cleared by `sts_clr_en` with a 1 in that bit of `sts_clr_data`. When a set and a clear arrive together, the set wins.
- R8: Micro-frame ticks are counted from reset or from the last window end. The tick that brings the count to the threshold ends the window, and `irq` rises only at such an edge, when `sts_q & intr_en` is nonzero. If the threshold is lowered below the current count, the next tick ends the window.
- R9: Once high, `irq` stays high while `sts_q & intr_en` is nonzero. It falls at the first edge where that value, seen before the edge, is zero.
- R10: A command write with bit 1 = 1 acts as a controller reset. It returns the command fields to the R1 value, restarts the micro-frame count, and discards any tick sampled at that edge. The status bits are not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cmd_wr_en | input | 1 | Command register write strobe |
| cmd_wr_data | input | 32 | Command write value |
| cmd_rd_data | output | 32 | Current command register value |
| sts_clr_en | input | 1 | Status write-one-to-clear strobe |
| sts_clr_data | input | NSTS | Status bits to clear |
| intr_en | input | NSTS | Per-bit interrupt enable |
| evt_set | input | NSTS | Status event pulses |
| uframe_tick | input | 1 | One-cycle pulse per micro-frame |
| adv_done | input | 1 | Schedule engine: cached state evicted |
| sts_q | output | NSTS | Status bits |
| async_adv_sts | output | 1 | Async-advance status bit |
| sched_async_en | output | 1 | Asynchronous schedule enable |
| irq | output | 1 | Interrupt line |

## Verification
The assertions check on every cycle that the stored threshold is always a legal one-hot value and that the doorbell can only rise when the schedule was already enabled. They also check that every fall of the doorbell comes with a posted async-advance status or a controller reset, that status bits rise only on a set source, and that the interrupt rises only on a tick and falls only when nothing enabled was pending. Only the bench's scenarios can show the window length for each threshold value, that a reserved threshold write is rejected, the one-cycle lag before the interrupt drops, and that a controller reset leaves the status bits alone. The bench shows these by running directed sequences and long random traffic against a cycle model.

// File: rtl/usb_cmd_pkg.sv
package usb_cmd_pkg;
  localparam int CMD_W      = 32;
  localparam int THR_LSB    = 16;
  localparam int THR_W      = 8;
  localparam int DB_BIT     = 6;
  localparam int AEN_BIT    = 5;
  localparam int CRST_BIT   = 1;
  localparam logic [THR_W-1:0] THR_RST = 8'h08;
  localparam int MAX_THR    = 64;
  localparam int CNT_W      = $clog2(MAX_THR);

  function automatic logic thr_legal(input logic [THR_W-1:0] v);
    return (v != '0) && !v[THR_W-1] && ((v & (v - 1'b1)) == '0);
  endfunction
endpackage

// File: rtl/usb_cmd_reg.sv
module usb_cmd_reg
  import usb_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_data,
  input  logic             adv_done,
  output logic [CMD_W-1:0] rd_data,
  output logic [THR_W-1:0] thr,
  output logic             async_en,
  output logic             doorbell,
  output logic             creset,
  output logic             adv_post
);
  logic [THR_W-1:0] thr_q;
  logic             en_q;
  logic             db_q;
  logic [THR_W-1:0] wr_thr;

  assign wr_thr   = wr_data[THR_LSB +: THR_W];
  assign creset   = wr_en && wr_data[CRST_BIT];
  assign adv_post = adv_done && db_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= THR_RST;
      en_q  <= 1'b0;
      db_q  <= 1'b0;
    end else if (creset) begin
      thr_q <= THR_RST;
      en_q  <= 1'b0;
      db_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        if (thr_legal(wr_thr)) thr_q <= wr_thr;
        en_q <= wr_data[AEN_BIT];
      end
      if (adv_post)
        db_q <= 1'b0;
      else if (wr_en && wr_data[DB_BIT] && en_q)
        db_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data                     = '0;
    rd_data[THR_LSB +: THR_W]   = thr_q;
    rd_data[DB_BIT]             = db_q;
    rd_data[AEN_BIT]            = en_q;
  end

  assign thr      = thr_q;
  assign async_en = en_q;
  assign doorbell = db_q;

  a_r2_thr_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q != '0) && $onehot0(thr_q) && !thr_q[THR_W-1]);

  a_r5_ring_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(db_q) |-> $past(en_q));
endmodule

// File: rtl/usb_sts_bank.sv
module usb_sts_bank #(
  parameter int NSTS      = 6,
  parameter int ASYNC_IDX = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSTS-1:0] evt_set,
  input  logic            adv_post,
  input  logic            clr_en,
  input  logic [NSTS-1:0] clr_data,
  output logic [NSTS-1:0] sts_q
);
  logic [NSTS-1:0] set_v;

  for (genvar i = 0; i < NSTS; i++) begin : g_bit
    if (i == ASYNC_IDX) begin : g_adv
      assign set_v[i] = adv_post;
    end else begin : g_evt
      assign set_v[i] = evt_set[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sts_q[i] <= 1'b0;
      else if (set_v[i])
        sts_q[i] <= 1'b1;
      else if (clr_en && clr_data[i])
        sts_q[i] <= 1'b0;
    end

    a_r7_rise_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q[i]) |-> $past(set_v[i]));
  end
endmodule

// File: rtl/usb_uframe_pacer.sv
module usb_uframe_pacer
  import usb_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             creset,
  input  logic [THR_W-1:0] thr,
  input  logic             pend,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q;
  logic [THR_W-1:0] cnt_ext;
  logic             window_end;
  logic             irq_q;

  assign cnt_ext    = THR_W'(cnt_q);
  assign window_end = tick && !creset && (cnt_ext >= (thr - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (creset)
        cnt_q <= '0;
      else if (window_end)
        cnt_q <= '0;
      else if (tick)
        cnt_q <= cnt_q + 1'b1;

      if (window_end)
        irq_q <= pend;
      else if (!pend)
        irq_q <= 1'b0;
    end
  end

  assign irq = irq_q;

  a_r8_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(tick));

  a_r9_fall_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> !$past(pend));
endmodule

// File: rtl/usb_cmd_pacer.sv
module usb_cmd_pacer
  import usb_cmd_pkg::*;
#(
  parameter int NSTS      = 6,
  parameter int ASYNC_IDX = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr_en,
  input  logic [CMD_W-1:0] cmd_wr_data,
  output logic [CMD_W-1:0] cmd_rd_data,
  input  logic             sts_clr_en,
  input  logic [NSTS-1:0]  sts_clr_data,
  input  logic [NSTS-1:0]  intr_en,
  input  logic [NSTS-1:0]  evt_set,
  input  logic             uframe_tick,
  input  logic             adv_done,
  output logic [NSTS-1:0]  sts_q,
  output logic             async_adv_sts,
  output logic             sched_async_en,
  output logic             irq
);
  logic [THR_W-1:0] thr;
  logic             doorbell;
  logic             creset;
  logic             adv_post;
  logic             pend;

  usb_cmd_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cmd_wr_en),
    .wr_data  (cmd_wr_data),
    .adv_done (adv_done),
    .rd_data  (cmd_rd_data),
    .thr      (thr),
    .async_en (sched_async_en),
    .doorbell (doorbell),
    .creset   (creset),
    .adv_post (adv_post)
  );

  usb_sts_bank #(.NSTS(NSTS), .ASYNC_IDX(ASYNC_IDX)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_set  (evt_set),
    .adv_post (adv_post),
    .clr_en   (sts_clr_en),
    .clr_data (sts_clr_data),
    .sts_q    (sts_q)
  );

  assign pend          = |(sts_q & intr_en);
  assign async_adv_sts = sts_q[ASYNC_IDX];

  usb_uframe_pacer u_pacer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (uframe_tick),
    .creset (creset),
    .thr    (thr),
    .pend   (pend),
    .irq    (irq)
  );

  a_r6_db_fall_posts: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(doorbell) |-> (sts_q[ASYNC_IDX] || $past(creset)));
endmodule

// File: tb/usb_cmd_pacer_tb.sv
module usb_cmd_pacer_tb_top;
  localparam int NS = 6;
  localparam int AI = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_wr_en = 1'b0;
  logic [31:0]   cmd_wr_data = '0;
  logic [31:0]   cmd_rd_data;
  logic          sts_clr_en = 1'b0;
  logic [NS-1:0] sts_clr_data = '0;
  logic [NS-1:0] intr_en = '0;
  logic [NS-1:0] evt_set = '0;
  logic          uframe_tick = 1'b0;
  logic          adv_done = 1'b0;
  logic [NS-1:0] sts_q;
  logic          async_adv_sts;
  logic          sched_async_en;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]    m_thr;
  logic          m_en, m_db, m_irq;
  logic [NS-1:0] m_sts;
  int            m_cnt;

  always #5 clk = ~clk;

  usb_cmd_pacer #(.NSTS(NS), .ASYNC_IDX(AI)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
    .cmd_rd_data(cmd_rd_data), .sts_clr_en(sts_clr_en), .sts_clr_data(sts_clr_data),
    .intr_en(intr_en), .evt_set(evt_set), .uframe_tick(uframe_tick),
    .adv_done(adv_done), .sts_q(sts_q), .async_adv_sts(async_adv_sts),
    .sched_async_en(sched_async_en), .irq(irq)
  );

  function automatic bit legal(input logic [7:0] v);
    return (v == 8'h01) || (v == 8'h02) || (v == 8'h04) || (v == 8'h08) ||
           (v == 8'h10) || (v == 8'h20) || (v == 8'h40);
  endfunction

  function automatic logic [31:0] exp_rd();
    return {8'h00, m_thr, 8'h00, 1'b0, m_db, m_en, 5'b00000};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_thr = 8'h08; m_en = 0; m_db = 0; m_irq = 0; m_sts = '0; m_cnt = 0;
  endtask

  task automatic model_edge();
    bit crst, post, pend, wend;
    logic [NS-1:0] setv, clrv;
    crst = cmd_wr_en && cmd_wr_data[1];
    post = adv_done && m_db;
    pend = |(m_sts & intr_en);
    wend = uframe_tick && !crst && (m_cnt >= int'(m_thr) - 1);
    m_irq = wend ? pend : (m_irq && pend);
    if (crst) m_cnt = 0;
    else if (wend) m_cnt = 0;
    else if (uframe_tick) m_cnt = m_cnt + 1;
    setv = evt_set;
    setv[AI] = post;
    clrv = sts_clr_en ? sts_clr_data : '0;
    m_sts = setv | (m_sts & ~clrv);
    if (crst) begin
      m_thr = 8'h08; m_en = 0; m_db = 0;
    end else begin
      if (m_db && adv_done) m_db = 0;
      else if (cmd_wr_en && cmd_wr_data[6] && m_en) m_db = 1;
      if (cmd_wr_en) begin
        if (legal(cmd_wr_data[23:16])) m_thr = cmd_wr_data[23:16];
        m_en = cmd_wr_data[5];
      end
    end
  endtask

  task automatic compare();
    check("R3 read value", cmd_rd_data, exp_rd());
    check("R4 schedule enable", {31'd0, sched_async_en}, {31'd0, m_en});
    check("R7 status", {26'd0, sts_q}, {26'd0, m_sts});
    check("R6 async status", {31'd0, async_adv_sts}, {31'd0, m_sts[AI]});
    check("R8 irq", {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic idle();
    cmd_wr_en = 0; sts_clr_en = 0; evt_set = '0; uframe_tick = 0; adv_done = 0;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic wr(input logic [31:0] d);
    cmd_wr_en = 1; cmd_wr_data = d; step();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin uframe_tick = 1; step(); end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset command", cmd_rd_data, 32'h0008_0000);
    check("R1 reset status", {26'd0, sts_q}, 32'd0);
    check("R1 reset irq", {31'd0, irq}, 32'd0);

    wr(32'hFF00_FF9D);
    check("R2 reserved threshold kept / R3 reserved bits", cmd_rd_data, 32'h0008_0000);
    wr(32'h0003_0000);
    check("R2 non-onehot threshold kept", cmd_rd_data, 32'h0008_0000);
    wr(32'h0080_0040);
    check("R5 ring while disabled ignored", cmd_rd_data, 32'h0008_0000);
    wr(32'h0004_0020);
    check("R4 enable and threshold 4", cmd_rd_data, 32'h0004_0020);
    wr(32'h0004_0060);
    check("R5 doorbell rung", cmd_rd_data, 32'h0004_0060);
    wr(32'h0004_0020);
    check("R5 write 0 keeps doorbell", cmd_rd_data, 32'h0004_0060);
    adv_done = 1; step();
    check("R6 doorbell cleared", cmd_rd_data, 32'h0004_0020);
    check("R6 status posted", {31'd0, async_adv_sts}, 32'd1);
    adv_done = 1; step();
    check("R6 idle adv_done no effect", cmd_rd_data, 32'h0004_0020);
    intr_en = 6'b100000;
    ticks(3);
    check("R8 no irq before window end", {31'd0, irq}, 32'd0);
    ticks(1);
    check("R8 irq at window end", {31'd0, irq}, 32'd1);
    sts_clr_en = 1; sts_clr_data = 6'b100000; step();
    check("R9 status cleared", {26'd0, sts_q}, 32'd0);
    check("R9 irq still high one cycle", {31'd0, irq}, 32'd1);
    step();
    check("R9 irq dropped", {31'd0, irq}, 32'd0);
    evt_set = 6'b100011; step();
    check("R7 async bit not set by evt", {26'd0, sts_q}, 32'h3);
    evt_set = 6'b000001; sts_clr_en = 1; sts_clr_data = 6'b000011; step();
    check("R7 set wins over clear", {26'd0, sts_q}, 32'h1);
    wr(32'h0040_0022);
    check("R10 controller reset", cmd_rd_data, 32'h0008_0000);
    check("R10 status untouched", {26'd0, sts_q}, 32'h1);
    intr_en = 6'b000001;
    ticks(7);
    check("R10 count restarted", {31'd0, irq}, 32'd0);
    ticks(1);
    check("R8 irq after 8 ticks", {31'd0, irq}, 32'd1);
    sts_clr_en = 1; sts_clr_data = '1; step(); step();

    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 15) begin
        logic [31:0] d;
        logic [7:0] t;
        d = $urandom();
        if ($urandom_range(0, 3) != 0) t = 8'h01 << $urandom_range(0, 6);
        else t = 8'($urandom());
        d[23:16] = t;
        if ($urandom_range(0, 39) != 0) d[1] = 1'b0;
        cmd_wr_en = 1; cmd_wr_data = d;
      end
      uframe_tick = ($urandom_range(0, 2) == 0);
      adv_done = ($urandom_range(0, 7) == 0);
      evt_set = ($urandom_range(0, 5) == 0) ? NS'($urandom()) : '0;
      if ($urandom_range(0, 4) == 0) begin
        sts_clr_en = 1; sts_clr_data = NS'($urandom());
      end
      if ($urandom_range(0, 49) == 0) intr_en = NS'($urandom());
      step();
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule